// File: doc/BRIEF.md
# Resistive Memory Bank Access Sequencer

This block produces the control timing for one bank of a resistive (magnetic junction) memory. It takes one request at a time, a read or a write, together with a row address, a data word, a temperature code and the word returned by the sense amplifiers. From these it drives the analog bank: sense-node precharge, the row word line, a dummy reference word line, the sense latch strobe, per-bit bitline and column-select high-voltage selects, a write-voltage level select and a wake signal for the write regulator.

A read charges the sense nodes for one cycle and then raises the row and reference word lines together. After a configurable settle time it strobes the latch and captures the sensed word. A write wakes the write regulator, then applies a programming pulse whose direction depends on each data bit. The regulator level comes from the temperature code, and colder codes get a stronger level. A verify read follows every pulse. A mismatch repeats the pulse, up to a configurable retry limit. When the limit is used up, the write finishes with an error. The analog circuits themselves stay outside this block.

Top module: `mram_bank_seq`

## Requirements
- R1: After reset every drive output, `busy`, `done`, `error`, `vlevel` and `rdata` are zero.
- R2: A request is taken only while `busy` is low. `busy` is high from the cycle after acceptance through the `done` cycle. Requests presented while busy are ignored.
- R3: A read holds `precharge` high for exactly one cycle. In the next cycle `wl_on` and `ref_wl` rise together, with `wl_row` equal to the address. While the reference line is up, all `bl_hv` and `cs_hv` bits are 0, which keeps the column select at ground.
- R4: `latch_en` is high for one cycle, exactly S cycles after the word lines rose, where S is the settle setting. The word lines stay up in that cycle. `rdata` takes `sense_data` from that cycle, and `done` follows one cycle later.
- R5: During a write pulse, a data bit of 1 gives `cs_hv`=1 and `bl_hv`=0 for that bit, and a data bit of 0 gives `bl_hv`=1 and `cs_hv`=0. The pulse lasts P cycles with `wl_on` high and `ref_wl` low.
- R6: `reg_wake` rises for a write in the first busy cycle. It holds for W cycles before the first pulse and stays high through `done`. Retries do not repeat the wake interval.
- R7: `vlevel` during a write is 3 for temperature codes 0 and 1, 2 for codes 2 and 3, 1 for codes 4 and 5, and 0 for codes 6 and 7. It is 0 when no write is running.
- R8: Each pulse is followed by a verify read of one precharge cycle, S sense cycles and a latch cycle. If the sensed word equals the write data, `done` follows with `error`=0.
- R9: A verify mismatch starts another pulse until 1+M pulses have been applied, where M is the retry setting. A mismatch after that pulse gives `done` with `error`=1.
- R10: The settings reset to settle 4, pulse 8, wake 6 and retries 4. `cfg_load` updates them only while idle. A zero settle, pulse or wake setting acts as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Row address |
| req_wdata | input | DW | Write data |
| temp_code | input | 3 | Die temperature code, 0 = coldest |
| sense_data | input | DW | Sense amplifier outputs |
| cfg_load | input | 1 | Load the settings below |
| cfg_settle | input | CW | Sense settle cycles |
| cfg_pulse | input | CW | Write pulse cycles |
| cfg_wake | input | CW | Regulator wake cycles |
| cfg_retry | input | RW | Maximum retries |
| wl_on | output | 1 | Row word line enable |
| wl_row | output | AW | Selected row, zero when off |
| ref_wl | output | 1 | Reference word line enable |
| precharge | output | 1 | Sense node precharge |
| latch_en | output | 1 | Sense latch strobe |
| bl_hv | output | DW | Bitline to programming voltage |
| cs_hv | output | DW | Column select to programming voltage |
| vlevel | output | 2 | Write voltage level |
| reg_wake | output | 1 | Write regulator wake |
| rdata | output | DW | Last latched word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished |
| error | output | 1 | Write failed verify, valid with done |

## Verification
The assertions check on every cycle the rules between signals. The reference line only ever rises with the row line and with no high-voltage select active. A precharge cycle is always followed by both word lines. The latch strobe never comes before the settle count has run out. Every pulse bit drives exactly one line, and only while the regulator is awake. The level stays fixed for a whole operation, and the pulse count stays within its bound. The bench scenarios are needed for the exact cycle counts, the temperature mapping, the retry and error outcome, the captured data, and the rule that requests and setting loads are ignored while busy.

// File: rtl/mram_seq_pkg.sv
package mram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SENSE,
    ST_LATCH,
    ST_WAKE,
    ST_PULSE,
    ST_FIN
  } seq_state_t;

  // colder code -> stronger level; upper two code bits select the step
  function automatic logic [1:0] level_from_temp(input logic [2:0] t);
    return 2'd3 - t[2:1];
  endfunction

endpackage

// File: rtl/mram_seq_cfg.sv
module mram_seq_cfg #(
  parameter int CW = 8,
  parameter int RW = 4,
  parameter int DEF_SETTLE = 4,
  parameter int DEF_PULSE  = 8,
  parameter int DEF_WAKE   = 6,
  parameter int DEF_RETRY  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [CW-1:0] settle_in,
  input  logic [CW-1:0] pulse_in,
  input  logic [CW-1:0] wake_in,
  input  logic [RW-1:0] retry_in,
  output logic [CW-1:0] settle_q,
  output logic [CW-1:0] pulse_q,
  output logic [CW-1:0] wake_q,
  output logic [RW-1:0] retry_q
);

  localparam logic [CW-1:0] RST_SETTLE = CW'(DEF_SETTLE);
  localparam logic [CW-1:0] RST_PULSE  = CW'(DEF_PULSE);
  localparam logic [CW-1:0] RST_WAKE   = CW'(DEF_WAKE);
  localparam logic [RW-1:0] RST_RETRY  = RW'(DEF_RETRY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= RST_SETTLE;
      pulse_q  <= RST_PULSE;
      wake_q   <= RST_WAKE;
      retry_q  <= RST_RETRY;
    end else if (load_en) begin
      settle_q <= settle_in;
      pulse_q  <= pulse_in;
      wake_q   <= wake_in;
      retry_q  <= retry_in;
    end
  end

endmodule

// File: rtl/mram_seq_timer.sv
module mram_seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  // cycles spent in the current state; a limit of zero behaves as one
  function automatic logic last_cycle(input logic [CW-1:0] c, input logic [CW-1:0] l);
    return ({1'b0, c} + (CW+1)'(1)) >= {1'b0, l};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (restart)         cnt_q <= '0;
    else if (cnt_q != '1)     cnt_q <= cnt_q + CW'(1);
  end

  assign expired = last_cycle(cnt_q, limit);

endmodule

// File: rtl/mram_write_drv.sv
module mram_write_drv #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse_on,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] bl_hv,
  output logic [DW-1:0] cs_hv
);

  // a one is written by raising column select; a zero by raising the bitline
  always_comb begin
    bl_hv = '0;
    cs_hv = '0;
    if (pulse_on) begin
      for (int i = 0; i < DW; i++) begin
        if (wdata[i]) cs_hv[i] = 1'b1;
        else          bl_hv[i] = 1'b1;
      end
    end
  end

  assert_one_line_per_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(bl_hv | cs_hv)) |-> ((bl_hv & cs_hv) == '0) && ((bl_hv | cs_hv) == '1));

endmodule

// File: rtl/mram_bank_seq.sv
module mram_bank_seq
  import mram_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 6,
  parameter int CW = 8,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [2:0]    temp_code,
  input  logic [DW-1:0] sense_data,
  input  logic          cfg_load,
  input  logic [CW-1:0] cfg_settle,
  input  logic [CW-1:0] cfg_pulse,
  input  logic [CW-1:0] cfg_wake,
  input  logic [RW-1:0] cfg_retry,
  output logic          wl_on,
  output logic [AW-1:0] wl_row,
  output logic          ref_wl,
  output logic          precharge,
  output logic          latch_en,
  output logic [DW-1:0] bl_hv,
  output logic [DW-1:0] cs_hv,
  output logic [1:0]    vlevel,
  output logic          reg_wake,
  output logic [DW-1:0] rdata,
  output logic          busy,
  output logic          done,
  output logic          error
);

  localparam int AT = RW + 1;

  seq_state_t    state_q, state_d;
  logic          is_wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [1:0]    lvl_q;
  logic          err_q;
  logic [AT-1:0] att_q;
  logic [DW-1:0] rdata_q;

  logic [CW-1:0] settle_c, pulse_c, wake_c;
  logic [RW-1:0] retry_c;
  logic [CW-1:0] tmr_limit;
  logic          tmr_exp;

  // named internal events
  logic accept_ev, verify_ok, out_of_tries, pulse_end;
  logic [AT-1:0] max_pulses;

  mram_seq_cfg #(.CW(CW), .RW(RW)) cfg_i (
    .clk(clk), .rst_n(rst_n),
    .load_en(cfg_load && (state_q == ST_IDLE)),
    .settle_in(cfg_settle), .pulse_in(cfg_pulse),
    .wake_in(cfg_wake), .retry_in(cfg_retry),
    .settle_q(settle_c), .pulse_q(pulse_c),
    .wake_q(wake_c), .retry_q(retry_c)
  );

  always_comb begin
    case (state_q)
      ST_WAKE:  tmr_limit = wake_c;
      ST_PULSE: tmr_limit = pulse_c;
      ST_SENSE: tmr_limit = settle_c;
      default:  tmr_limit = CW'(1);
    endcase
  end

  mram_seq_timer #(.CW(CW)) tmr_i (
    .clk(clk), .rst_n(rst_n),
    .restart(state_d != state_q),
    .limit(tmr_limit),
    .expired(tmr_exp)
  );

  assign accept_ev    = (state_q == ST_IDLE) && req_valid;
  assign verify_ok    = (sense_data == wdata_q);
  assign max_pulses   = {1'b0, retry_c} + AT'(1);
  assign out_of_tries = (att_q >= max_pulses);
  assign pulse_end    = (state_q == ST_PULSE) && tmr_exp;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_valid) state_d = req_write ? ST_WAKE : ST_PRE;
      ST_WAKE:  if (tmr_exp) state_d = ST_PULSE;
      ST_PULSE: if (tmr_exp) state_d = ST_PRE;
      ST_PRE:   state_d = ST_SENSE;
      ST_SENSE: if (tmr_exp) state_d = ST_LATCH;
      ST_LATCH: begin
        if (!is_wr_q || verify_ok || out_of_tries) state_d = ST_FIN;
        else                                        state_d = ST_PULSE;
      end
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      is_wr_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      lvl_q   <= '0;
      err_q   <= 1'b0;
      att_q   <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept_ev) begin
        is_wr_q <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        lvl_q   <= level_from_temp(temp_code);
        err_q   <= 1'b0;
        att_q   <= '0;
      end
      if (pulse_end) att_q <= att_q + AT'(1);
      if (state_q == ST_LATCH) begin
        rdata_q <= sense_data;
        if (is_wr_q && !verify_ok && out_of_tries) err_q <= 1'b1;
      end
    end
  end

  mram_write_drv #(.DW(DW)) drv_i (
    .clk(clk), .rst_n(rst_n),
    .pulse_on(state_q == ST_PULSE),
    .wdata(wdata_q),
    .bl_hv(bl_hv), .cs_hv(cs_hv)
  );

  assign precharge = (state_q == ST_PRE);
  assign ref_wl    = (state_q == ST_SENSE) || (state_q == ST_LATCH);
  assign wl_on     = ref_wl || (state_q == ST_PULSE);
  assign wl_row    = wl_on ? addr_q : '0;
  assign latch_en  = (state_q == ST_LATCH);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign error     = done && err_q;
  assign reg_wake  = busy && is_wr_q;
  assign vlevel    = reg_wake ? lvl_q : 2'd0;
  assign rdata     = rdata_q;

  // checker state: cycles the reference line has been up
  logic [CW:0] wl_age_q;
  logic [CW:0] settle_eff;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wl_age_q <= '0;
    else if (!ref_wl)          wl_age_q <= '0;
    else if (wl_age_q != '1)   wl_age_q <= wl_age_q + (CW+1)'(1);
  end
  assign settle_eff = (settle_c == '0) ? (CW+1)'(1) : {1'b0, settle_c};

  assert_ref_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_wl |-> wl_on && (bl_hv == '0) && (cs_hv == '0));

  assert_pre_then_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
    precharge |=> wl_on && ref_wl && !precharge);

  assert_latch_after_settle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    latch_en |-> (wl_age_q >= settle_eff));

  assert_done_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_pulse_awake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(bl_hv | cs_hv)) |-> reg_wake && wl_on && !ref_wl);

  assert_level_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(vlevel));

  assert_pulse_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (att_q <= max_pulses));

endmodule

// File: tb/mram_bank_seq_tb_top.sv
module mram_bank_seq_tb_top;

  localparam int DW = 8;
  localparam int AW = 6;
  localparam int CW = 8;
  localparam int RW = 4;
  localparam int VW = 8 + 2 + AW + 3*DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 0, req_write = 0, cfg_load = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, sense_data = '0;
  logic [2:0]    temp_code = '0;
  logic [CW-1:0] cfg_settle = '0, cfg_pulse = '0, cfg_wake = '0;
  logic [RW-1:0] cfg_retry = '0;

  logic          wl_on, ref_wl, precharge, latch_en, reg_wake, busy, done, error;
  logic [AW-1:0] wl_row;
  logic [DW-1:0] bl_hv, cs_hv, rdata;
  logic [1:0]    vlevel;

  mram_bank_seq #(.DW(DW), .AW(AW), .CW(CW), .RW(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .temp_code(temp_code),
    .sense_data(sense_data), .cfg_load(cfg_load), .cfg_settle(cfg_settle),
    .cfg_pulse(cfg_pulse), .cfg_wake(cfg_wake), .cfg_retry(cfg_retry),
    .wl_on(wl_on), .wl_row(wl_row), .ref_wl(ref_wl), .precharge(precharge),
    .latch_en(latch_en), .bl_hv(bl_hv), .cs_hv(cs_hv), .vlevel(vlevel),
    .reg_wake(reg_wake), .rdata(rdata), .busy(busy), .done(done), .error(error)
  );

  wire [VW-1:0] act_vec = {busy, done, error, precharge, wl_on, ref_wl, latch_en,
                           reg_wake, vlevel, wl_row, bl_hv, cs_hv, rdata};

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  // model state
  int m_settle = 4, m_pulse = 8, m_wake = 6, m_retry = 4;
  logic [DW-1:0] m_rdata = '0;
  bit op_wr, fin_err;
  logic [1:0] op_lvl;
  logic [AW-1:0] op_row;
  logic [DW-1:0] op_d;
  bit poke_req = 0, poke_cfg = 0;

  logic [VW-1:0] exp_q[$];
  logic [DW-1:0] sns_q[$];
  string         tag_q[$];

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [1:0] temp_level(input int t);
    if (t < 2) return 2'd3;
    if (t < 4) return 2'd2;
    if (t < 6) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [VW-1:0] idle_vec();
    return {8'b0, 2'b0, {AW{1'b0}}, {DW{1'b0}}, {DW{1'b0}}, m_rdata};
  endfunction

  task automatic push(input string tag, input bit pre, input bit wl, input bit rf,
                      input bit lat, input bit pls, input bit fin, input logic [DW-1:0] sv);
    logic [VW-1:0] v;
    v = {1'b1, fin, fin & fin_err, pre, wl, rf, lat, op_wr,
         op_wr ? op_lvl : 2'b0, wl ? op_row : {AW{1'b0}},
         pls ? ~op_d : {DW{1'b0}}, pls ? op_d : {DW{1'b0}}, m_rdata};
    exp_q.push_back(v);
    sns_q.push_back(sv);
    tag_q.push_back(tag);
  endtask

  task automatic check(input string tag, input logic [VW-1:0] exp);
    n_checks++;
    if (act_vec !== exp) begin
      n_errors++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act_vec, exp);
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) begin
      @(negedge clk);
      req_valid  = poke_req;
      cfg_load   = poke_cfg;
      sense_data = sns_q.pop_front();
      check(tag_q.pop_front(), exp_q.pop_front());
    end
    req_valid = 0;
    cfg_load  = 0;
    @(negedge clk);
    sense_data = '0;
    check("R2 back to idle after done", idle_vec());
  endtask

  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input int t);
    @(negedge clk);
    check("R2 idle before request", idle_vec());
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; temp_code = 3'(t);
    op_wr = wr; op_row = a; op_d = d; op_lvl = temp_level(t); fin_err = 0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] sv);
    issue(0, a, 8'h00, 0);
    push("R3 precharge", 1, 0, 0, 0, 0, 0, '0);
    for (int i = 0; i < eff(m_settle); i++) push("R3 word lines", 0, 1, 1, 0, 0, 0, '0);
    push("R4 latch", 0, 1, 1, 1, 0, 0, sv);
    m_rdata = sv;
    push("R4 done with data", 0, 0, 0, 0, 0, 1, '0);
    drain();
  endtask

  // fails: number of verifies that read back the inverted word
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int t, input int fails);
    logic [DW-1:0] sv;
    issue(1, a, d, t);
    for (int i = 0; i < eff(m_wake); i++) push("R6 wake", 0, 0, 0, 0, 0, 0, '0);
    for (int at = 1; at <= m_retry + 1; at++) begin
      for (int i = 0; i < eff(m_pulse); i++) push("R5 pulse", 0, 1, 0, 0, 1, 0, '0);
      push("R8 verify precharge", 1, 0, 0, 0, 0, 0, '0);
      for (int i = 0; i < eff(m_settle); i++) push("R8 verify sense", 0, 1, 1, 0, 0, 0, '0);
      sv = (at <= fails) ? ~d : d;
      push("R8 verify latch", 0, 1, 1, 1, 0, 0, sv);
      m_rdata = sv;
      if (at > fails) begin
        push("R8 done ok", 0, 0, 0, 0, 0, 1, '0);
        break;
      end
      if (at == m_retry + 1) begin
        fin_err = 1;
        push("R9 done with error", 0, 0, 0, 0, 0, 1, '0);
      end
    end
    drain();
  endtask

  task automatic load_cfg(input int s, input int p, input int w, input int r);
    @(negedge clk);
    check("R10 idle before load", idle_vec());
    cfg_load = 1; cfg_settle = CW'(s); cfg_pulse = CW'(p); cfg_wake = CW'(w);
    cfg_retry = RW'(r);
    @(negedge clk);
    cfg_load = 0;
    check("R10 idle after load", idle_vec());
    m_settle = s; m_pulse = p; m_wake = w; m_retry = r;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", idle_vec());
    rst_n = 1;
    @(negedge clk);
    check("R1 state after reset release", idle_vec());

    // defaults: settle 4, pulse 8, wake 6, retries 4 (R10)
    do_read(6'h2A, 8'hA5);
    poke_req = 1;                       // R2: requests while busy are ignored
    do_read(6'h11, 8'h5C);
    poke_req = 0;
    do_write(6'h03, 8'h3C, 0, 0);       // R7 code 0 -> level 3
    do_write(6'h3F, 8'hF0, 1, 4);       // R9 pass on last allowed pulse
    do_write(6'h05, 8'h81, 3, 0);       // R7 code 3 -> level 2

    load_cfg(2, 3, 2, 2);
    do_read(6'h07, 8'h69);
    do_write(6'h08, 8'hC3, 5, 2);       // R9 retries then pass, code 5 -> level 1
    do_write(6'h09, 8'h0F, 7, 3);       // R9 exhausted -> error, code 7 -> level 0
    do_write(6'h0A, 8'h96, 4, 5);       // R9 error again, code 4 -> level 1

    // R10: setting loads while busy are ignored
    cfg_settle = 9; cfg_pulse = 9; cfg_wake = 9; cfg_retry = 0;
    poke_cfg = 1;
    do_read(6'h0B, 8'h42);
    poke_cfg = 0;
    do_write(6'h0C, 8'h55, 2, 0);       // still old settings, code 2 -> level 2

    load_cfg(0, 0, 0, 0);               // R10 zero acts as one cycle
    do_write(6'h0D, 8'hAA, 6, 1);       // no retries -> error on first mismatch
    do_read(6'h0E, 8'h18);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule